// File: doc/BRIEF.md
# Partitioned SIMD Lane Adder

This block adds two 32-bit words as packed groups of narrow values. A 2-bit mode input picks the lane width. The word can be one 32-bit lane, two 16-bit lanes, or four 8-bit lanes. Every lane is summed separately inside one adder pass. The carry chain is broken at each active lane edge, so a lane wraps modulo 2^width and never disturbs the lane above it. Typical uses are pixel channels or audio samples held side by side in one register.

Each lane's carry-out is reported in a 4-bit vector. The bit used is the one that matches the top byte of that lane. A build parameter can place a result register behind the adder. The register loads on a valid strobe, holds between strobes, and is cleared by a synchronous active-high reset.

Top module: `simd_lane_adder`

## Requirements
- R1: With modeSel = 2'b10, sumOut[8k+7:8k] equals (opA byte k + opB byte k) mod 256 for k = 0..3.
- R2: With modeSel = 2'b01, sumOut[31:16] and sumOut[15:0] each equal the matching halfword sum of opA and opB mod 65536.
- R3: With modeSel = 2'b00, sumOut equals (opA + opB) mod 2^32.
- R4: modeSel = 2'b11 gives the same sumOut and carryOut as modeSel = 2'b00.
- R5: No carry crosses an active lane boundary. For example, 0xFF + 0x01 in an 8-bit lane gives 0x00 in that lane and leaves the lane above it unchanged.
- R6: carryOut[i] is the carry out of the lane whose top byte is byte i, and every other carryOut bit is 0. Only bit 3 can be set in 32-bit mode, only bits 1 and 3 in 16-bit mode, and all four bits are in use in 8-bit mode.
- R7: When REGISTERED = 1, sumOut and carryOut load only on a clock edge where inValid is 1. They keep their value while inValid is 0, even if the operands or the mode change.
- R8: A synchronous rst = 1 clears sumOut, carryOut and outValid to 0 at the next clock edge.
- R9: When REGISTERED = 1, outValid equals the value inValid had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe that loads a new result |
| modeSel | input | 2 | Lane width: 00 = 32-bit, 01 = 16-bit, 10 = 8-bit, 11 = same as 00 |
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand |
| sumOut | output | 32 | Packed lane sums |
| carryOut | output | 4 | Carry out of each lane, at the bit of the lane's top byte |
| outValid | output | 1 | Marks that sumOut and carryOut hold a new result |

## Verification
All-ones plus 0x01010101 is applied in every mode, and this single pattern tells the three lane widths apart. It wraps every 8-bit lane to zero. It leaves 0x0100 in each 16-bit lane. It propagates into a single 32-bit sum. A carry that leaks across a lane edge therefore shows up as a wrong neighbour byte. Alternating-byte patterns check that a carry in one lane leaves the idle lane next to it untouched. The reserved mode code is compared directly against the 32-bit result. Random operands in all four modes are checked against a per-lane model, and idle cycles with changed operands check that the register holds.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int SEG_W   = 8;
  localparam int NUM_SEG = 4;
  localparam int DATA_W  = SEG_W * NUM_SEG;
  localparam int HALF_SEGS = NUM_SEG / 2;

  typedef enum logic [1:0] {
    MODE_W32  = 2'b00,
    MODE_W16  = 2'b01,
    MODE_W8   = 2'b10,
    MODE_RSVD = 2'b11
  } laneMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SEG-1:0] cutBelow;    // segment starts a new lane (no carry in)
    logic [NUM_SEG-1:0] reportCarry; // segment is the top of a lane
    logic               loadEn;
  } laneCtrl_t;
endpackage

// File: rtl/lane_add_ctrl.sv
module lane_add_ctrl
  import simd_add_pkg::*;
(
  input  logic      inValid,
  input  laneMode_e mode,
  output laneCtrl_t ctrl
);
  function automatic logic [NUM_SEG-1:0] startMask(input int perLane);
    logic [NUM_SEG-1:0] m;
    for (int k = 0; k < NUM_SEG; k++) m[k] = ((k % perLane) == 0);
    return m;
  endfunction

  function automatic logic [NUM_SEG-1:0] topMask(input int perLane);
    logic [NUM_SEG-1:0] m;
    for (int k = 0; k < NUM_SEG; k++) m[k] = (((k + 1) % perLane) == 0);
    return m;
  endfunction

  always_comb begin
    ctrl.loadEn = inValid;
    case (mode)
      MODE_W8: begin
        ctrl.cutBelow    = startMask(1);
        ctrl.reportCarry = topMask(1);
      end
      MODE_W16: begin
        ctrl.cutBelow    = startMask(HALF_SEGS);
        ctrl.reportCarry = topMask(HALF_SEGS);
      end
      default: begin  // 32-bit and reserved code
        ctrl.cutBelow    = startMask(NUM_SEG);
        ctrl.reportCarry = topMask(NUM_SEG);
      end
    endcase
  end
endmodule

// File: rtl/lane_add_dp.sv
module lane_add_dp
  import simd_add_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  laneCtrl_t         ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] sumOut,
  output logic [NUM_SEG-1:0] carryOut,
  output logic              outValid
);
  logic [DATA_W-1:0]  rawSum;
  logic [NUM_SEG-1:0] segCo;
  logic [NUM_SEG-1:0] segCi;
  logic [NUM_SEG-1:0] carryNext;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign segCi[k] = 1'b0;
    end else begin : g_rest
      assign segCi[k] = ctrl.cutBelow[k] ? 1'b0 : segCo[k-1];
    end
    assign {segCo[k], rawSum[k*SEG_W +: SEG_W]} =
      {1'b0, opA[k*SEG_W +: SEG_W]} + {1'b0, opB[k*SEG_W +: SEG_W]} + {{SEG_W{1'b0}}, segCi[k]};

    AST_LANE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
      ctrl.cutBelow[k] |-> ({segCo[k], rawSum[k*SEG_W +: SEG_W]} ==
        ({1'b0, opA[k*SEG_W +: SEG_W]} + {1'b0, opB[k*SEG_W +: SEG_W]}))); // R5
  end

  assign carryNext = segCo & ctrl.reportCarry;

  if (REGISTERED) begin : g_reg
    logic [DATA_W-1:0]  sumQ;
    logic [NUM_SEG-1:0] carryQ;
    logic               validQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        sumQ   <= '0;
        carryQ <= '0;
        validQ <= 1'b0;
      end else begin
        validQ <= ctrl.loadEn;
        if (ctrl.loadEn) begin
          sumQ   <= rawSum;
          carryQ <= carryNext;
        end
      end
    end

    assign sumOut   = sumQ;
    assign carryOut = carryQ;
    assign outValid = validQ;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !ctrl.loadEn |=> ($stable(sumOut) && $stable(carryOut))); // R7
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      ctrl.loadEn |=> outValid); // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
      !ctrl.loadEn |=> !outValid); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (sumOut == '0 && carryOut == '0 && !outValid)); // R8
  end else begin : g_comb
    assign sumOut   = rawSum;
    assign carryOut = carryNext;
    assign outValid = ctrl.loadEn;
  end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] sumOut,
  output logic [NUM_SEG-1:0] carryOut,
  output logic              outValid
);
  laneCtrl_t laneCtrl;

  lane_add_ctrl u_ctrl (
    .inValid (inValid),
    .mode    (laneMode_e'(modeSel)),
    .ctrl    (laneCtrl)
  );

  lane_add_dp #(.REGISTERED(REGISTERED)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (laneCtrl),
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut),
    .carryOut (carryOut),
    .outValid (outValid)
  );
endmodule

// File: tb/simd_lane_adder_tb.sv
module simd_lane_adder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] sumOut;
  logic [3:0]  carryOut;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  simd_lane_adder u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .modeSel(modeSel),
    .opA(opA), .opB(opB), .sumOut(sumOut), .carryOut(carryOut), .outValid(outValid)
  );

  // per-lane reference model: {carry[3:0], sum[31:0]}
  function automatic logic [35:0] refAdd(input logic [31:0] a, input logic [31:0] b,
                                         input logic [1:0] m);
    int w;
    logic [32:0] mask;
    logic [32:0] t;
    logic [31:0] s;
    logic [3:0]  c;
    w = (m == 2'b10) ? 8 : (m == 2'b01) ? 16 : 32;
    mask = (33'd1 << w) - 33'd1;
    s = '0;
    c = '0;
    for (int lo = 0; lo < 32; lo += w) begin
      t = (({1'b0, a} >> lo) & mask) + (({1'b0, b} >> lo) & mask);
      s = s | (t[31:0] & mask[31:0]) << lo;
      c[(lo + w) / 8 - 1] = t[w];
    end
    return {c, s};
  endfunction

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b10:   return "R1/R5/R6";
      2'b01:   return "R2/R5/R6";
      2'b00:   return "R3/R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m);
    @(negedge clk);
    opA = a; opB = b; modeSel = m; inValid = 1'b1;
    @(posedge clk);
    #1;
    check(modeTag(m), {carryOut, sumOut}, refAdd(a, b, m));
    check("R9 valid", {35'd0, outValid}, 36'd1);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin : stim
    logic [35:0] held;
    logic [31:0] ra;
    logic [31:0] rb;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset state", {carryOut, sumOut}, 36'd0);
    check("R8 reset valid", {35'd0, outValid}, 36'd0);
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    doOp(32'hFFFF_FFFF, 32'h0101_0101, 2'b10);
    check("R1 R5 R6 all lanes wrap", {carryOut, sumOut}, {4'b1111, 32'h0000_0000});
    doOp(32'hFFFF_FFFF, 32'h0101_0101, 2'b01);
    check("R2 R5 R6 halves", {carryOut, sumOut}, {4'b1010, 32'h0100_0100});
    doOp(32'hFFFF_FFFF, 32'h0101_0101, 2'b00);
    check("R3 R6 full word", {carryOut, sumOut}, {4'b1000, 32'h0101_0100});
    doOp(32'hFFFF_FFFF, 32'h0101_0101, 2'b11);
    check("R4 reserved as 32-bit", {carryOut, sumOut}, {4'b1000, 32'h0101_0100});
    doOp(32'h00FF_00FF, 32'h0001_0001, 2'b10);
    check("R5 neighbour untouched", {carryOut, sumOut}, {4'b0101, 32'h0000_0000});
    doOp(32'h0000_FFFF, 32'h0000_0001, 2'b01);
    check("R5 R6 low half wraps", {carryOut, sumOut}, {4'b0010, 32'h0000_0000});
    doOp(32'h8000_0000, 32'h8000_0000, 2'b00);
    check("R3 R6 top carry", {carryOut, sumOut}, {4'b1000, 32'h0000_0000});

    // hold while idle
    held = {carryOut, sumOut};
    @(negedge clk);
    opA = 32'h1234_5678; opB = 32'h9ABC_DEF0; modeSel = 2'b10;
    @(posedge clk); #1;
    check("R7 hold while idle", {carryOut, sumOut}, held);
    check("R9 valid low", {35'd0, outValid}, 36'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) rb = ~ra;
      doOp(ra, rb, 2'($urandom_range(0, 3)));
    end

    // reset mid-run
    doOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R8 sync reset clears", {carryOut, sumOut}, 36'd0);
    check("R8 sync reset valid", {35'd0, outValid}, 36'd0);
    @(negedge clk);
    rst = 1'b0;
    doOp(32'h7F7F_7F7F, 32'h0101_0101, 2'b10);

    done = 1'b1;
    finishRun();
  end
endmodule